// File: doc/BRIEF.md
# Byte/Word Memory Bus Decoder

This block connects a 16-bit CPU load/store port to a set of 16-bit-wide on-chip memory regions inside a 21-bit byte address space. Every request is decoded into one region (program flash, static RAM, a low-endurance data EEPROM, a high-endurance data EEPROM, boot ROM, or nothing). The block then steers the byte lanes for byte or word transfers in little-endian order and returns a one-cycle response.

Writes to regions that cannot be written are dropped without effect. Program flash accepts only aligned word accesses. A flash read can be given one extra wait cycle through a configuration input. A word access at an odd address is carried out as two byte-lane cycles and is flagged in the response. The writable regions are modelled as small synchronous arrays that alias inside their windows. Flash and boot ROM hold computed contents.

Top module: `mbd_bus_decoder`

## Requirements
- R1: Region decode, reported on `sel_region` during each lane cycle, uses these codes: 0 none, 1 flash (0x00000–0x0BFFF and 0x1C000–0x1FFFF), 2 RAM (0x0C000–0x0CBFF), 3 low-endurance EEPROM (0x0F000–0x0F7FF), 4 high-endurance EEPROM (0x0F800–0x0F87F), 5 boot ROM (0x0E000–0x0E5FF). Any other address, including every address at or above 0x20000, selects none.
- R2: An aligned word read of flash returns `addr[16:1] ^ 16'h5A5A`. An aligned word read of boot ROM returns `addr[16:1] ^ 16'hC3C3`.
- R3: An aligned word write to flash, and any write to boot ROM, completes without error and leaves the contents unchanged. `lane_we` stays low for such writes.
- R4: A byte access of flash, or a word access of flash at an odd address, is a disabled access. It follows the error rule of R8.
- R5: In the writable regions a word at address A holds its low byte at A and its high byte at A+1. A byte read returns the addressed byte zero-extended in `rsp_rdata[7:0]`. A byte write takes its data from `req_wdata[7:0]`.
- R6: `lane_be` is 2'b11 for an aligned word, 2'b01 for a byte at an even address, 2'b10 for a byte at an odd address, and 2'b00 for a lane that is unmapped or disabled.
- R7: A word access at an odd address runs two lane cycles: first the byte at A, then the byte at A+1. `misalign` is high together with `rsp_valid`. The response comes 3 cycles after acceptance.
- R8: An access where any lane is unmapped or disabled gives `rsp_err` high for exactly the response cycle with `rsp_rdata` = 16'hFFFF. A successful write returns `rsp_rdata` = 0.
- R9: A response normally appears 2 cycles after the accepting clock edge. A flash read with `cfg_flash_wait` = 1 takes 3 cycles.
- R10: `req_ready` is high only while idle. It is low from the cycle after acceptance until the response cycle has passed. `rsp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_flash_wait | input | 1 | 1 adds one wait cycle to flash reads |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Unmapped or disabled access |
| misalign | output | 1 | Word access at odd address |
| sel_region | output | 3 | Region of the current lane |
| lane_be | output | 2 | Byte-lane enables of the current lane |
| lane_we | output | 1 | Array write strobe of the current lane |

## Verification
Aligned words, even and odd bytes, and odd-address words are sent to the same RAM locations. Reading back each pattern separates correct little-endian lane placement from swapped or duplicated lanes. Flash reads with and without the wait bit separate the latency paths. Flash writes followed by reads show whether the drop rule holds. Accesses just past region ends, above the populated window, and a misaligned word whose second byte leaves its region show whether the error path is taken by each lane on its own.

// File: rtl/mbd_pkg.sv
// Package: shared region codes and memory-map constants for the bus decoder.
// Assumes a 21-bit byte address; all regions are 16 bits wide.
package mbd_pkg;
    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_FLASH = 3'd1,
        RG_RAM   = 3'd2,
        RG_EELO  = 3'd3,
        RG_EEHI  = 3'd4,
        RG_BOOT  = 3'd5
    } region_t;

    localparam int unsigned ADDR_W = 21;
    localparam logic [15:0] FLASH_KEY = 16'h5A5A;
    localparam logic [15:0] BOOT_KEY  = 16'hC3C3;
endpackage

// File: rtl/mbd_region_dec.sv
// Module: combinational address-to-region decoder.
// Assumes addresses at or above the populated 128K window select nothing.
module mbd_region_dec
    import mbd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    logic [16:0] a;
    assign a = addr[16:0];

    // Decode one byte address into a region code.
    always_comb begin
        region = RG_NONE;
        if (addr[ADDR_W-1:17] == '0) begin
            if (a < 17'h0C000 || a >= 17'h1C000)           region = RG_FLASH;
            else if (a >= 17'h0C000 && a < 17'h0CC00)      region = RG_RAM;
            else if (a >= 17'h0E000 && a < 17'h0E600)      region = RG_BOOT;
            else if (a >= 17'h0F000 && a < 17'h0F800)      region = RG_EELO;
            else if (a >= 17'h0F800 && a < 17'h0F880)      region = RG_EEHI;
        end
    end
endmodule

// File: rtl/mbd_data_bank.sv
// Module: storage for the writable regions plus computed flash/boot contents.
// Assumes each writable array aliases within its window (word index = low bits).
module mbd_data_bank
    import mbd_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic        clk,
    input  region_t     region,
    input  logic [15:0] widx,
    input  logic [1:0]  be,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] rdata
);
    localparam int unsigned IW     = $clog2(DEPTH);
    localparam int unsigned N_ARR  = 3;

    logic [15:0] arr_rd [N_ARR];

    for (genvar g = 0; g < N_ARR; g++) begin : g_arr
        localparam int unsigned CODE = 2 + g;
        logic [15:0] mem [DEPTH];

        // Byte-lane write into this array when it is the selected region.
        always_ff @(posedge clk) begin
            if (we && region == region_t'(CODE[2:0])) begin
                if (be[0]) mem[widx[IW-1:0]][7:0]  <= wdata[7:0];
                if (be[1]) mem[widx[IW-1:0]][15:8] <= wdata[15:8];
            end
        end
        assign arr_rd[g] = mem[widx[IW-1:0]];
    end

    // Select the read word of the current region.
    always_comb begin
        case (region)
            RG_FLASH: rdata = widx ^ FLASH_KEY;
            RG_BOOT:  rdata = widx ^ BOOT_KEY;
            RG_RAM:   rdata = arr_rd[0];
            RG_EELO:  rdata = arr_rd[1];
            RG_EEHI:  rdata = arr_rd[2];
            default:  rdata = 16'hFFFF;
        endcase
    end
endmodule

// File: rtl/mbd_bus_decoder.sv
// Module: CPU load/store front end to the on-chip memory regions.
// Accepts one request while idle, runs one or two lane cycles, optionally a
// flash wait cycle, then gives a one-cycle response. Assumes the CPU holds no
// second request until req_ready returns.
module mbd_bus_decoder
    import mbd_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_flash_wait,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_word,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [15:0]         req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [15:0]         rsp_rdata,
    output logic                rsp_err,
    output logic                misalign,
    output logic [2:0]          sel_region,
    output logic [1:0]          lane_be,
    output logic                lane_we
);
    typedef enum logic [2:0] {ST_IDLE, ST_LO, ST_HI, ST_WAIT, ST_RESP} state_t;

    state_t            state;
    logic              q_write, q_word, err_acc;
    logic [ADDR_W-1:0] q_addr;
    logic [15:0]       q_wdata;
    logic [7:0]        res_lo, res_hi;

    logic              in_lane, is_misal, full_word, bad;
    logic [ADDR_W-1:0] cur_addr;
    region_t           region;
    logic [1:0]        be_raw;
    logic [7:0]        wbyte, rbyte;
    logic [15:0]       lane_wdata, bank_rd;

    assign in_lane   = (state == ST_LO) || (state == ST_HI);
    assign is_misal  = q_word && q_addr[0];
    assign full_word = q_word && !q_addr[0];
    assign cur_addr  = (state == ST_HI) ? q_addr + 1'b1 : q_addr;

    mbd_region_dec u_dec (.addr(cur_addr), .region(region));

    // Lane enables, disable rule and write-lane data for the current lane.
    always_comb begin
        be_raw     = full_word ? 2'b11 : (cur_addr[0] ? 2'b10 : 2'b01);
        bad        = (region == RG_NONE) || (region == RG_FLASH && !full_word);
        wbyte      = (state == ST_HI) ? q_wdata[15:8] : q_wdata[7:0];
        lane_wdata = full_word ? q_wdata : {wbyte, wbyte};
        rbyte      = cur_addr[0] ? bank_rd[15:8] : bank_rd[7:0];
    end

    assign sel_region = in_lane ? region : RG_NONE;
    assign lane_be    = (in_lane && !bad) ? be_raw : 2'b00;
    assign lane_we    = in_lane && !bad && q_write &&
                        (region == RG_RAM || region == RG_EELO || region == RG_EEHI);

    mbd_data_bank #(.DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .region(region),
        .widx  (cur_addr[16:1]),
        .be    (lane_be),
        .we    (lane_we),
        .wdata (lane_wdata),
        .rdata (bank_rd)
    );

    // Request capture, lane sequencing and result accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            q_write <= 1'b0;
            q_word  <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            res_lo  <= '0;
            res_hi  <= '0;
            err_acc <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    q_write <= req_write;
                    q_word  <= req_word;
                    q_addr  <= req_addr;
                    q_wdata <= req_wdata;
                    err_acc <= 1'b0;
                    state   <= ST_LO;
                end
                ST_LO: begin
                    err_acc <= bad;
                    if (full_word) begin
                        res_lo <= bank_rd[7:0];
                        res_hi <= bank_rd[15:8];
                    end else begin
                        res_lo <= rbyte;
                        res_hi <= 8'h00;
                    end
                    if (is_misal)
                        state <= ST_HI;
                    else if (region == RG_FLASH && !bad && !q_write && cfg_flash_wait)
                        state <= ST_WAIT;
                    else
                        state <= ST_RESP;
                end
                ST_HI: begin
                    err_acc <= err_acc | bad;
                    res_hi  <= rbyte;
                    state   <= ST_RESP;
                end
                ST_WAIT: state <= ST_RESP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RESP);
    assign rsp_err   = rsp_valid && err_acc;
    assign misalign  = rsp_valid && is_misal;
    assign rsp_rdata = !rsp_valid ? 16'h0000 :
                       err_acc    ? 16'hFFFF :
                       q_write    ? 16'h0000 : {res_hi, res_lo};
endmodule

// File: rtl/mbd_bus_decoder_chk.sv
// Module: protocol checker for the bus decoder, bound to every instance.
// Assumes only the top-level ports are visible.
module mbd_bus_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [15:0] rsp_rdata,
    input logic        rsp_err,
    input logic        misalign,
    input logic [2:0]  sel_region,
    input logic [1:0]  lane_be,
    input logic        lane_we
);
    p_no_write_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we |-> (sel_region == 3'd2 || sel_region == 3'd3 || sel_region == 3'd4));
    p_none_no_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_region == 3'd0) |-> (lane_be == 2'b00));
    p_err_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 16'hFFFF));
    p_misal_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> rsp_valid);
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_rsp_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

bind mbd_bus_decoder mbd_bus_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .misalign(misalign), .sel_region(sel_region), .lane_be(lane_be),
    .lane_we(lane_we)
);

// File: tb/mbd_bus_decoder_tb_top.sv
// Bench: directed scenarios, one task each, checking against the requirements.
module mbd_bus_decoder_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_flash_wait = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err, misalign, lane_we;
    logic [15:0] rsp_rdata;
    logic [2:0]  sel_region;
    logic [1:0]  lane_be;

    int checks = 0, failures = 0;
    logic [15:0] o_data; logic o_err, o_mis, o_we, o_rdy1;
    logic [2:0] o_reg; logic [1:0] o_be; int o_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbd_bus_decoder dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transaction; records first-lane signals, latency and response.
    task automatic xfer(input bit wr, input bit wd, input logic [20:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        @(posedge clk); #1 req_valid = 1'b0;
        o_lat = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == 1) begin o_reg = sel_region; o_be = lane_be; o_we = lane_we; o_rdy1 = req_ready; end
            if (rsp_valid) begin o_lat = k; o_data = rsp_rdata; o_err = rsp_err; o_mis = misalign; break; end
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 pulse/ready", {rsp_valid, req_ready}, 2'b01);
        chk(o_rdy1 == 1'b0, "R10 busy", o_rdy1, 0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R10 reset", {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic t_flash();
        cfg_flash_wait = 1'b0;
        xfer(0, 1, 21'h00100, 0);
        chk(o_data == 16'h5ADA && o_lat == 2, "R2/R9 flash read", {o_data, 8'(o_lat)}, {16'h5ADA, 8'd2});
        chk(o_reg == 3'd1 && o_be == 2'b11, "R1/R6 flash lane", {o_reg, o_be}, {3'd1, 2'b11});
        cfg_flash_wait = 1'b1;
        xfer(0, 1, 21'h1C000, 0);
        chk(o_data == 16'hBA5A && o_lat == 3, "R9 flash wait", {o_data, 8'(o_lat)}, {16'hBA5A, 8'd3});
        cfg_flash_wait = 1'b0;
        xfer(1, 1, 21'h00100, 16'h1111);
        chk(o_we == 0 && o_err == 0, "R3 flash write dropped", {o_we, o_err}, 0);
        xfer(0, 1, 21'h00100, 0);
        chk(o_data == 16'h5ADA, "R3 flash unchanged", o_data, 16'h5ADA);
        xfer(0, 0, 21'h00101, 0);
        chk(o_err == 1 && o_data == 16'hFFFF, "R4 flash byte", {o_err, o_data}, {1'b1, 16'hFFFF});
        xfer(0, 1, 21'h00103, 0);
        chk(o_err == 1, "R4 flash odd word", o_err, 1);
    endtask

    task automatic t_ram_lanes();
        xfer(1, 1, 21'h0C010, 16'h1234);
        chk(o_be == 2'b11 && o_we == 1 && o_reg == 3'd2 && o_data == 0, "R6/R8 ram word write", {o_be, o_we, o_reg}, {2'b11, 1'b1, 3'd2});
        xfer(0, 0, 21'h0C010, 0);
        chk(o_data == 16'h0034 && o_be == 2'b01, "R5/R6 even byte", o_data, 16'h0034);
        xfer(0, 0, 21'h0C011, 0);
        chk(o_data == 16'h0012 && o_be == 2'b10, "R5/R6 odd byte", o_data, 16'h0012);
        xfer(1, 0, 21'h0C011, 16'h00AB);
        chk(o_be == 2'b10, "R6 odd byte write be", o_be, 2'b10);
        xfer(0, 1, 21'h0C010, 0);
        chk(o_data == 16'hAB34, "R5 byte merge", o_data, 16'hAB34);
    endtask

    task automatic t_misalign();
        xfer(1, 1, 21'h0C012, 16'h0000);
        xfer(1, 1, 21'h0C014, 16'h0000);
        xfer(1, 1, 21'h0C013, 16'hBEEF);
        chk(o_mis == 1 && o_lat == 3 && o_err == 0, "R7 misaligned write", {o_mis, 8'(o_lat)}, {1'b1, 8'd3});
        xfer(0, 1, 21'h0C012, 0);
        chk(o_data == 16'hEF00, "R7 low word", o_data, 16'hEF00);
        xfer(0, 1, 21'h0C014, 0);
        chk(o_data == 16'h00BE, "R7 high word", o_data, 16'h00BE);
        xfer(0, 1, 21'h0C013, 0);
        chk(o_data == 16'hBEEF && o_mis == 1, "R7 misaligned read", o_data, 16'hBEEF);
        xfer(0, 1, 21'h0F87F, 0);
        chk(o_err == 1 && o_data == 16'hFFFF && o_reg == 3'd4, "R8 crossing end", {o_err, o_data}, {1'b1, 16'hFFFF});
    endtask

    task automatic t_map();
        xfer(0, 1, 21'h0D000, 0);
        chk(o_err == 1 && o_data == 16'hFFFF && o_reg == 0 && o_be == 0, "R8/R1 hole", {o_err, o_data}, {1'b1, 16'hFFFF});
        xfer(0, 1, 21'h100000, 0);
        chk(o_err == 1 && o_reg == 0, "R1 above window", {o_err, o_reg}, {1'b1, 3'd0});
        xfer(1, 1, 21'h0CC00, 16'h1);
        chk(o_err == 1 && o_we == 0, "R1/R8 ram end write", {o_err, o_we}, 2'b10);
        xfer(0, 1, 21'h0E002, 0);
        chk(o_data == 16'hB3C2 && o_reg == 3'd5, "R2 boot read", o_data, 16'hB3C2);
        xfer(1, 1, 21'h0E002, 16'h0);
        chk(o_we == 0 && o_err == 0, "R3 boot write", {o_we, o_err}, 0);
        xfer(0, 1, 21'h0E002, 0);
        chk(o_data == 16'hB3C2, "R3 boot unchanged", o_data, 16'hB3C2);
        xfer(1, 1, 21'h0F020, 16'h55AA);
        xfer(0, 1, 21'h0F020, 0);
        chk(o_data == 16'h55AA && o_reg == 3'd3, "R1/R5 eeprom low", o_data, 16'h55AA);
        xfer(1, 1, 21'h0F840, 16'hC0DE);
        xfer(0, 1, 21'h0F840, 0);
        chk(o_data == 16'hC0DE && o_reg == 3'd4, "R1/R5 eeprom high", o_data, 16'hC0DE);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        failures++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flash();
        t_ram_lanes();
        t_misalign();
        t_map();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule